// File: doc/BRIEF.md
# Branch Decode and Target Unit

This unit sits beside the execute stage of an 8-bit core that runs the classic 8051 instruction set. Every cycle it is handed an opcode with up to two operand bytes and the current operand context: the address of the opcode, the accumulator, the carry flag, the value of a tested bit, a byte already read from a register, indirect or direct location, the data pointer and a return address popped from the stack. From these it works out what any control-transfer instruction does. It reports the instruction length and cycle count, whether the branch is taken, and where execution goes next.

It also reports each instruction's side effects: a decremented byte and its write strobe for the decrement-and-branch forms, a clear strobe for the jump-and-clear-bit form, a new carry for the compare-and-branch forms, a push request with the return address for calls, and a release pulse for return-from-interrupt. Opcode A5 is an extension whose meaning comes from a 4-bit mode input. One mode makes it a program-memory write with a post-increment of the data pointer. Another makes it a software break. All results are registered, so they appear one clock after the inputs are presented.

Top module: `br_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output becomes zero on that edge.
- R2: `len` gives the instruction length in bytes. It is 1 for NOP (00), RET (22), RETI (32), jump-indirect (73), A5 and undefined opcodes. It is 2 for absolute jump and call (low five opcode bits 01 and 11), SJMP (80), JC (40), JNC (50), JZ (60), JNZ (70) and DJNZ on a register (D8–DF). It is 3 for LJMP (02), LCALL (12), JBC (10), JB (20), JNB (30), every compare-and-branch (B4–BF) and DJNZ on a direct byte (D5).
- R3: `cycles` is 2 for every jump, call, return, compare and decrement-branch, and for A5 in write mode. It is 1 for NOP, for A5 in break mode and for undefined opcodes.
- R4: For an absolute jump or call, the target is bits 15:11 of `inst_pc`+2, then opcode bits 7:5, then `op1`. It is always taken.
- R5: LJMP and LCALL target {`op1`,`op2`} and are always taken. Calls (absolute and long) raise `push_req`. `push_addr` always equals `inst_pc`+`len` (mod 2^16).
- R6: SJMP is always taken. JC and JNC branch on `cy_in`=1 and 0. JZ and JNZ branch on `acc` zero and nonzero. The displacement `op1` is sign-extended and added to `inst_pc`+2. A not-taken instruction of any kind reports `target` = `inst_pc`+`len`.
- R7: JB branches on `bit_in`=1, JNB on `bit_in`=0 and JBC on `bit_in`=1. The displacement is `op2`. `bit_clr` is high exactly when JBC is taken.
- R8: Compare-and-branch pairs are `acc` with `op1` (B4), `acc` with `opnd` (B5), and `opnd` with `op1` (B6–BF). It branches by `op2` when the pair differs. It sets `cy_we` and `cy_out` = (first < second, unsigned). For every other opcode `cy_we`=0 and `cy_out`=`cy_in`.
- R9: DJNZ raises `dec_we` with `dec_val`=`opnd`−1 (mod 256) and branches when that value is nonzero. The displacement is `op1` for D8–DF and `op2` for D5. Otherwise `dec_we`=0 and `dec_val`=0. `reg_sel` is opcode bits 2:0 for B8–BF and D8–DF, opcode bit 0 for B6–B7, and 0 otherwise.
- R10: Jump-indirect targets `dptr`+`acc` (mod 2^16). RET and RETI target `ret_addr`. All three are always taken. `irq_rel` is high only for RETI.
- R11: For A5 with `ext_mode`=WR_MODE (default 4'hA), `pgm_wr` and `dptr_inc` are high. With `ext_mode`=BRK_MODE (default 4'h5), `brk_req` is high. Neither form is taken. With any other mode, A5 is undefined.
- R12: An undefined opcode reports not taken and raises no side-effect output.
- R13: Outputs change only on a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Instruction opcode |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| inst_pc | input | 16 | Address of the opcode byte |
| acc | input | 8 | Accumulator |
| cy_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the addressed bit |
| opnd | input | 8 | Byte read from register, indirect or direct location |
| dptr | input | 16 | Data pointer |
| ret_addr | input | 16 | Return address popped from stack |
| ext_mode | input | 4 | Extension mode for opcode A5 |
| len | output | 2 | Instruction length in bytes |
| cycles | output | 2 | Cycle count |
| taken | output | 1 | Control transfer happens |
| target | output | 16 | Next execution address |
| push_req | output | 1 | Call pushes return address |
| push_addr | output | 16 | Next sequential address |
| dec_we | output | 1 | Write back decremented byte |
| dec_val | output | 8 | Decremented byte |
| bit_clr | output | 1 | Clear the tested bit |
| cy_we | output | 1 | Carry update strobe |
| cy_out | output | 1 | New carry |
| reg_sel | output | 3 | Register number from opcode |
| irq_rel | output | 1 | Interrupt-level release |
| pgm_wr | output | 1 | Program-memory write request |
| dptr_inc | output | 1 | Increment data pointer |
| brk_req | output | 1 | Software break request |

## Verification
The bench sweeps all 256 opcodes in each of three extension modes against a set of operand patterns. These patterns force equal and unequal compare operands, an accumulator of zero, a decrement that reaches zero, negative displacements and address wrap at FFFF. A design that took the sign of the displacement wrongly, or added it to the opcode address rather than the following one, would miss a target. A design that swapped the compare operands would invert the carry. One that left the decrement on a wrapped zero taken, or that decoded the A5 modes the wrong way round, would raise the wrong strobe. The absolute-jump page bits are checked with `inst_pc` values near a 2 KB boundary, where the kept upper bits come from the incremented address.

// File: rtl/br_unit_pkg.sv
package br_unit_pkg;

    localparam int OPC_W = 8;
    localparam int BYTE_W = 8;

    typedef enum logic [4:0] {
        K_NONE, K_NOP, K_AJMP, K_ACALL, K_LJMP, K_LCALL, K_RET, K_RETI,
        K_SJMP, K_JC, K_JNC, K_JZ, K_JNZ, K_JB, K_JNB, K_JBC, K_JMPI,
        K_CJ_AI, K_CJ_AD, K_CJ_IND, K_CJ_REG, K_DJ_REG, K_DJ_DIR,
        K_XWR, K_TRAP
    } br_kind_e;

    typedef struct packed {
        br_kind_e   kind;
        logic [1:0] len;
        logic [1:0] cyc;
        logic [2:0] rsel;
    } br_dec_t;

    function automatic br_dec_t br_decode_fn(
        input logic [OPC_W-1:0] opc,
        input logic [3:0]       xm,
        input logic [3:0]       wr_m,
        input logic [3:0]       bk_m
    );
        br_dec_t d;
        d.kind = K_NONE;
        d.rsel = 3'd0;
        if (opc[4:0] == 5'h01)      d.kind = K_AJMP;
        else if (opc[4:0] == 5'h11) d.kind = K_ACALL;
        else begin
            casez (opc)
                8'h00: d.kind = K_NOP;
                8'h02: d.kind = K_LJMP;
                8'h12: d.kind = K_LCALL;
                8'h22: d.kind = K_RET;
                8'h32: d.kind = K_RETI;
                8'h80: d.kind = K_SJMP;
                8'h40: d.kind = K_JC;
                8'h50: d.kind = K_JNC;
                8'h60: d.kind = K_JZ;
                8'h70: d.kind = K_JNZ;
                8'h10: d.kind = K_JBC;
                8'h20: d.kind = K_JB;
                8'h30: d.kind = K_JNB;
                8'h73: d.kind = K_JMPI;
                8'hB4: d.kind = K_CJ_AI;
                8'hB5: d.kind = K_CJ_AD;
                8'b1011_011?: begin d.kind = K_CJ_IND; d.rsel = {2'b00, opc[0]}; end
                8'b1011_1???: begin d.kind = K_CJ_REG; d.rsel = opc[2:0]; end
                8'hD5: d.kind = K_DJ_DIR;
                8'b1101_1???: begin d.kind = K_DJ_REG; d.rsel = opc[2:0]; end
                8'hA5: begin
                    if (xm == wr_m)      d.kind = K_XWR;
                    else if (xm == bk_m) d.kind = K_TRAP;
                end
                default: d.kind = K_NONE;
            endcase
        end
        case (d.kind)
            K_AJMP, K_ACALL, K_SJMP, K_JC, K_JNC, K_JZ, K_JNZ, K_DJ_REG: d.len = 2'd2;
            K_LJMP, K_LCALL, K_JB, K_JNB, K_JBC,
            K_CJ_AI, K_CJ_AD, K_CJ_IND, K_CJ_REG, K_DJ_DIR:              d.len = 2'd3;
            default:                                                    d.len = 2'd1;
        endcase
        case (d.kind)
            K_NONE, K_NOP, K_TRAP: d.cyc = 2'd1;
            default:               d.cyc = 2'd2;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_unit_pkg::*;
#(
    parameter logic [3:0] WR_MODE  = 4'hA,
    parameter logic [3:0] BRK_MODE = 4'h5
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [3:0]       ext_mode,
    output br_dec_t          dec
);
    always_comb dec = br_decode_fn(opcode, ext_mode, WR_MODE, BRK_MODE);
endmodule

// File: rtl/br_eval.sv
module br_eval
    import br_unit_pkg::*;
(
    input  br_kind_e          kind,
    input  logic [BYTE_W-1:0] acc,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [BYTE_W-1:0] opnd,
    input  logic [BYTE_W-1:0] op1,
    input  logic [BYTE_W-1:0] op2,
    output logic              taken,
    output logic [BYTE_W-1:0] disp,
    output logic              cy_out,
    output logic              cy_we,
    output logic [BYTE_W-1:0] dec_val,
    output logic              dec_we,
    output logic              bit_clr
);
    logic [BYTE_W-1:0] lhs, rhs, dm1;

    always_comb begin
        dm1 = opnd - 1'b1;
        lhs = acc;
        rhs = op1;
        case (kind)
            K_CJ_AD:            rhs = opnd;
            K_CJ_IND, K_CJ_REG: lhs = opnd;
            default: ;
        endcase
    end

    always_comb begin
        taken   = 1'b0;
        disp    = op1;
        cy_out  = cy_in;
        cy_we   = 1'b0;
        dec_val = '0;
        dec_we  = 1'b0;
        bit_clr = 1'b0;
        case (kind)
            K_AJMP, K_ACALL, K_LJMP, K_LCALL,
            K_RET, K_RETI, K_SJMP, K_JMPI: taken = 1'b1;
            K_JC:  taken = cy_in;
            K_JNC: taken = ~cy_in;
            K_JZ:  taken = (acc == '0);
            K_JNZ: taken = (acc != '0);
            K_JB:  begin taken = bit_in;  disp = op2; end
            K_JNB: begin taken = ~bit_in; disp = op2; end
            K_JBC: begin taken = bit_in;  disp = op2; bit_clr = bit_in; end
            K_CJ_AI, K_CJ_AD, K_CJ_IND, K_CJ_REG: begin
                taken  = (lhs != rhs);
                disp   = op2;
                cy_we  = 1'b1;
                cy_out = (lhs < rhs);
            end
            K_DJ_REG, K_DJ_DIR: begin
                dec_we  = 1'b1;
                dec_val = dm1;
                taken   = (dm1 != '0);
                disp    = (kind == K_DJ_DIR) ? op2 : op1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br_addr.sv
module br_addr
    import br_unit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  br_kind_e          kind,
    input  logic [1:0]        len,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              taken,
    input  logic [ADDR_W-1:0] inst_pc,
    input  logic [BYTE_W-1:0] op1,
    input  logic [BYTE_W-1:0] op2,
    input  logic [BYTE_W-1:0] disp,
    input  logic [BYTE_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] seq,
    output logic [ADDR_W-1:0] target
);
    localparam int PAGE_LO = 11;
    logic [ADDR_W-1:0] rel;

    always_comb begin
        seq = inst_pc + ADDR_W'(len);
        rel = seq + {{(ADDR_W-BYTE_W){disp[BYTE_W-1]}}, disp};
        target = seq;
        if (taken) begin
            case (kind)
                K_AJMP, K_ACALL: target = {seq[ADDR_W-1:PAGE_LO], opcode[7:5], op1};
                K_LJMP, K_LCALL: target = ADDR_W'({op1, op2});
                K_RET, K_RETI:   target = ret_addr;
                K_JMPI:          target = dptr + ADDR_W'(acc);
                default:         target = rel;
            endcase
        end
    end
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_unit_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter logic [3:0] WR_MODE  = 4'hA,
    parameter logic [3:0] BRK_MODE = 4'h5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        opcode,
    input  logic [7:0]        op1,
    input  logic [7:0]        op2,
    input  logic [ADDR_W-1:0] inst_pc,
    input  logic [7:0]        acc,
    input  logic              cy_in,
    input  logic              bit_in,
    input  logic [7:0]        opnd,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [3:0]        ext_mode,
    output logic [1:0]        len,
    output logic [1:0]        cycles,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_addr,
    output logic              dec_we,
    output logic [7:0]        dec_val,
    output logic              bit_clr,
    output logic              cy_we,
    output logic              cy_out,
    output logic [2:0]        reg_sel,
    output logic              irq_rel,
    output logic              pgm_wr,
    output logic              dptr_inc,
    output logic              brk_req
);
    br_dec_t           dec;
    logic              tk_c, cyo_c, cyw_c, dwe_c, bclr_c;
    logic [7:0]        disp_c, dval_c;
    logic [ADDR_W-1:0] seq_c, tgt_c;
    logic              push_c, rel_c, wr_c, brk_c;

    br_decode #(.WR_MODE(WR_MODE), .BRK_MODE(BRK_MODE)) u_dec (
        .opcode(opcode), .ext_mode(ext_mode), .dec(dec)
    );

    br_eval u_eval (
        .kind(dec.kind), .acc(acc), .cy_in(cy_in), .bit_in(bit_in), .opnd(opnd),
        .op1(op1), .op2(op2), .taken(tk_c), .disp(disp_c), .cy_out(cyo_c),
        .cy_we(cyw_c), .dec_val(dval_c), .dec_we(dwe_c), .bit_clr(bclr_c)
    );

    br_addr #(.ADDR_W(ADDR_W)) u_addr (
        .kind(dec.kind), .len(dec.len), .opcode(opcode), .taken(tk_c),
        .inst_pc(inst_pc), .op1(op1), .op2(op2), .disp(disp_c), .acc(acc),
        .dptr(dptr), .ret_addr(ret_addr), .seq(seq_c), .target(tgt_c)
    );

    assign push_c = (dec.kind == K_ACALL) || (dec.kind == K_LCALL);
    assign rel_c  = (dec.kind == K_RETI);
    assign wr_c   = (dec.kind == K_XWR);
    assign brk_c  = (dec.kind == K_TRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            len <= '0; cycles <= '0; taken <= 1'b0; target <= '0;
            push_req <= 1'b0; push_addr <= '0; dec_we <= 1'b0; dec_val <= '0;
            bit_clr <= 1'b0; cy_we <= 1'b0; cy_out <= 1'b0; reg_sel <= '0;
            irq_rel <= 1'b0; pgm_wr <= 1'b0; dptr_inc <= 1'b0; brk_req <= 1'b0;
        end else begin
            len       <= dec.len;
            cycles    <= dec.cyc;
            taken     <= tk_c;
            target    <= tgt_c;
            push_req  <= push_c;
            push_addr <= seq_c;
            dec_we    <= dwe_c;
            dec_val   <= dval_c;
            bit_clr   <= bclr_c;
            cy_we     <= cyw_c;
            cy_out    <= cyo_c;
            reg_sel   <= dec.rsel;
            irq_rel   <= rel_c;
            pgm_wr    <= wr_c;
            dptr_inc  <= wr_c;
            brk_req   <= brk_c;
        end
    end

    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (len == 2'd0 && !taken && target == '0 && !push_req));

    assert_undef_R12: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == K_NONE) |-> (!tk_c && dec.len == 2'd1 && dec.cyc == 2'd1 && !dwe_c && !cyw_c));

    assert_bitclr_R7: assert property (@(posedge clk) disable iff (rst)
        bclr_c |-> (tk_c && dec.kind == K_JBC && dec.len == 2'd3));

    assert_strobes_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_c, brk_c, push_c, rel_c, dwe_c}));

    assert_carry_R8: assert property (@(posedge clk) disable iff (rst)
        !cyw_c |-> (cyo_c == cy_in));

    assert_djnz_R9: assert property (@(posedge clk) disable iff (rst)
        (dwe_c && tk_c) |-> (dval_c != 8'd0));

    assert_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
        !tk_c |-> (tgt_c == seq_c));
endmodule

// File: tb/br_unit_test.sv
module br_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  opcode, op1, op2, acc, opnd;
    logic [15:0] inst_pc, dptr, ret_addr;
    logic        cy_in, bit_in;
    logic [3:0]  ext_mode;
    logic [1:0]  len, cycles;
    logic        taken, push_req, dec_we, bit_clr, cy_we, cy_out;
    logic        irq_rel, pgm_wr, dptr_inc, brk_req;
    logic [15:0] target, push_addr;
    logic [7:0]  dec_val;
    logic [2:0]  reg_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    br_unit uut (
        .clk(clk), .rst(rst), .opcode(opcode), .op1(op1), .op2(op2),
        .inst_pc(inst_pc), .acc(acc), .cy_in(cy_in), .bit_in(bit_in),
        .opnd(opnd), .dptr(dptr), .ret_addr(ret_addr), .ext_mode(ext_mode),
        .len(len), .cycles(cycles), .taken(taken), .target(target),
        .push_req(push_req), .push_addr(push_addr), .dec_we(dec_we),
        .dec_val(dec_val), .bit_clr(bit_clr), .cy_we(cy_we), .cy_out(cy_out),
        .reg_sel(reg_sel), .irq_rel(irq_rel), .pgm_wr(pgm_wr),
        .dptr_inc(dptr_inc), .brk_req(brk_req)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s op=%02h mode=%h got=%0h exp=%0h", req, what, opcode, ext_mode, got, exp);
        end
    endtask

    // expected values from the requirements
    logic [1:0]  e_len, e_cyc;
    logic        e_tk, e_push, e_dwe, e_bclr, e_cyw, e_cyo, e_rel, e_wr, e_brk;
    logic [15:0] e_tgt, e_seq;
    logic [7:0]  e_dval;
    logic [2:0]  e_rsel;
    string       e_tag;

    task automatic model();
        logic [7:0]  a, b, d;
        logic        is_aj, is_ac, cj;
        logic [15:0] rel_t;
        e_len = 1; e_cyc = 1; e_tk = 0; e_push = 0; e_dwe = 0; e_dval = 0;
        e_bclr = 0; e_cyw = 0; e_cyo = cy_in; e_rel = 0; e_wr = 0; e_brk = 0;
        e_rsel = 0; e_tag = "R12"; d = op1;
        is_aj = (opcode[4:0] == 5'h01);
        is_ac = (opcode[4:0] == 5'h11);
        cj = 0; a = 0; b = 0;
        if (is_aj || is_ac) begin
            e_len = 2; e_cyc = 2; e_tk = 1; e_push = is_ac; e_tag = "R4";
        end else if (opcode == 8'h00) begin
            e_tag = "R3";
        end else if (opcode == 8'h02 || opcode == 8'h12) begin
            e_len = 3; e_cyc = 2; e_tk = 1; e_push = (opcode == 8'h12); e_tag = "R5";
        end else if (opcode == 8'h22 || opcode == 8'h32 || opcode == 8'h73) begin
            e_cyc = 2; e_tk = 1; e_rel = (opcode == 8'h32); e_tag = "R10";
        end else if (opcode == 8'h80 || opcode == 8'h40 || opcode == 8'h50 || opcode == 8'h60 || opcode == 8'h70) begin
            e_len = 2; e_cyc = 2; e_tag = "R6";
            case (opcode)
                8'h80: e_tk = 1;
                8'h40: e_tk = cy_in;
                8'h50: e_tk = !cy_in;
                8'h60: e_tk = (acc == 0);
                default: e_tk = (acc != 0);
            endcase
        end else if (opcode == 8'h10 || opcode == 8'h20 || opcode == 8'h30) begin
            e_len = 3; e_cyc = 2; e_tag = "R7"; d = op2;
            e_tk = (opcode == 8'h30) ? !bit_in : bit_in;
            e_bclr = (opcode == 8'h10) && bit_in;
        end else if (opcode >= 8'hB4 && opcode <= 8'hBF) begin
            e_len = 3; e_cyc = 2; e_tag = "R8"; d = op2; cj = 1;
            if (opcode == 8'hB4) begin a = acc; b = op1; end
            else if (opcode == 8'hB5) begin a = acc; b = opnd; end
            else begin a = opnd; b = op1; end
            if (opcode >= 8'hB8) e_rsel = opcode[2:0];
            else if (opcode >= 8'hB6) e_rsel = {2'b00, opcode[0]};
            e_tk = (a != b); e_cyw = 1; e_cyo = (a < b);
        end else if (opcode == 8'hD5 || opcode >= 8'hD8 && opcode <= 8'hDF) begin
            e_cyc = 2; e_tag = "R9"; e_dwe = 1; e_dval = opnd - 8'd1;
            e_tk = (e_dval != 0);
            if (opcode == 8'hD5) begin e_len = 3; d = op2; end
            else begin e_len = 2; e_rsel = opcode[2:0]; end
        end else if (opcode == 8'hA5 && ext_mode == 4'hA) begin
            e_cyc = 2; e_wr = 1; e_tag = "R11";
        end else if (opcode == 8'hA5 && ext_mode == 4'h5) begin
            e_brk = 1; e_tag = "R11";
        end
        e_seq = inst_pc + 16'(e_len);
        rel_t = e_seq + {{8{d[7]}}, d};
        if (!e_tk) e_tgt = e_seq;
        else if (is_aj || is_ac) e_tgt = {e_seq[15:11], opcode[7:5], op1};
        else if (opcode == 8'h02 || opcode == 8'h12) e_tgt = {op1, op2};
        else if (opcode == 8'h22 || opcode == 8'h32) e_tgt = ret_addr;
        else if (opcode == 8'h73) e_tgt = dptr + {8'h00, acc};
        else e_tgt = rel_t;
    endtask

    task automatic check_all();
        chk("R2", "len", 32'(len), 32'(e_len));
        chk("R3", "cycles", 32'(cycles), 32'(e_cyc));
        chk(e_tag, "taken", 32'(taken), 32'(e_tk));
        chk(e_tag, "target", 32'(target), 32'(e_tgt));
        chk("R5", "push_req", 32'(push_req), 32'(e_push));
        chk("R5", "push_addr", 32'(push_addr), 32'(e_seq));
        chk("R9", "dec_we", 32'(dec_we), 32'(e_dwe));
        chk("R9", "dec_val", 32'(dec_val), 32'(e_dval));
        chk("R9", "reg_sel", 32'(reg_sel), 32'(e_rsel));
        chk("R7", "bit_clr", 32'(bit_clr), 32'(e_bclr));
        chk("R8", "cy_we", 32'(cy_we), 32'(e_cyw));
        chk("R8", "cy_out", 32'(cy_out), 32'(e_cyo));
        chk("R10", "irq_rel", 32'(irq_rel), 32'(e_rel));
        chk("R11", "pgm_wr", 32'(pgm_wr), 32'(e_wr));
        chk("R11", "dptr_inc", 32'(dptr_inc), 32'(e_wr));
        chk("R11", "brk_req", 32'(brk_req), 32'(e_brk));
    endtask

    task automatic set_pattern(input int op, input int p, input logic [3:0] m);
        opcode   = 8'(op);
        ext_mode = m;
        op1      = 8'(p * 53) ^ 8'(op);
        op2      = p[0] ? (8'h80 | 8'(p * 7)) : 8'(p * 11);
        acc      = (p == 0) ? 8'h00 : (p == 6) ? op1 : 8'(p * 37 + op);
        opnd     = (p == 2) ? 8'h01 : (p == 3) ? op1 : (p == 4) ? acc : (p == 7) ? 8'h00 : 8'(p * 29 + op);
        cy_in    = p[0];
        bit_in   = p[1];
        inst_pc  = (p == 5) ? 16'hFFFE : (p == 1) ? 16'h07FE : 16'(p * 16'h1357 + op * 16'h0101);
        dptr     = 16'hFFF0 + 16'(p * 3);
        ret_addr = 16'h8000 ^ 16'(op * 16'h0203 + p);
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_pattern(8'h12, 3, 4'h0);
        repeat (2) @(posedge clk);
        #5;
        // R1: reset clears every output
        chk("R1", "len", 32'(len), 0);
        chk("R1", "taken", 32'(taken), 0);
        chk("R1", "target", 32'(target), 0);
        chk("R1", "push", 32'({push_req, push_addr}), 0);
        chk("R1", "strobes", 32'({dec_we, bit_clr, cy_we, irq_rel, pgm_wr, dptr_inc, brk_req, cycles}), 0);
        rst = 1'b0;

        for (int m = 0; m < 3; m++) begin
            for (int op = 0; op < 256; op++) begin
                for (int p = 0; p < 8; p++) begin
                    set_pattern(op, p, (m == 0) ? 4'hA : (m == 1) ? 4'h5 : 4'h3);
                    model();
                    @(posedge clk);
                    #5;
                    check_all();
                end
            end
        end

        // R13: outputs hold until the next edge after an input change
        set_pattern(8'h02, 2, 4'hA);
        model();
        @(posedge clk);
        #5;
        set_pattern(8'h00, 0, 4'hA);
        #5;
        chk("R13", "len held", 32'(len), 32'(2'd3));
        chk("R13", "target held", 32'(target), 32'(e_tgt));
        model();
        @(posedge clk);
        #5;
        chk("R13", "len updated", 32'(len), 32'(2'd1));

        // R1: reset mid-run clears state again
        rst = 1'b1;
        set_pattern(8'h11, 1, 4'hA);
        @(posedge clk);
        #5;
        chk("R1", "mid reset", 32'({taken, push_req, len}), 0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule